// File: doc/BRIEF.md
# Chained Vector Register Execution Unit

This block is a register-to-register vector engine. It holds eight vector registers of 64 elements, each element 64 bits wide, and runs two functional units side by side: a pipelined adder and a pipelined multiplier. Each instruction names a destination register and two sources. The second source can be a scalar value that is broadcast to every element. A vector-length register sets how many leading elements each instruction processes. The value of that register is captured when the instruction issues. Integer add and integer multiply stand in for the floating-point arithmetic.

An instruction may read a register that the other unit is still writing. In that case it does not wait for the whole register. It takes element i in the same cycle that element i leaves the producer's pipeline, forwarded past the register file. A dependent add/multiply pair therefore finishes in about one vector length plus both pipeline latencies, and both units stay busy together. The issue logic holds a request off in three cases: its own unit is occupied, its destination is still being written, or its destination is still being read by the other unit. This keeps results equal to strict program order.

A narrow fill port and a combinational peek port reach single elements. They stand in for the load and store paths that lie outside this block.

Top module: `vec_chain_unit`

## Requirements
- R1: After reset every element of every register reads zero, both done outputs are low, and `iss_ready` is high for any request.
- R2: `vl_val` value 0 encodes length 64; any other value n encodes length n. An instruction writes elements 0 to length-1 of its destination and leaves the other elements unchanged.
- R3: With `iss_op` = 0, destination element i becomes the sum of the source elements modulo 2^64.
- R4: With `iss_op` = 1, destination element i becomes the low 64 bits of the product of the source elements.
- R5: With `iss_bsc` = 1, `iss_scalar` replaces every element of the second source. `iss_srcb` is then ignored.
- R6: An unchained instruction accepted in cycle c writes its last element, and pulses its done output, in cycle c + length + L. L is 3 for the adder and 5 for the multiplier.
- R7: An instruction on the other unit that reads the destination of an in-flight instruction chains. If a multiply reading an add's destination is accepted in cycle c+1, after that add was accepted in cycle c, the multiply's done output pulses in cycle c + length + 8. Its results equal sequential execution.
- R8: A request for a unit that is still working keeps `iss_ready` low. Two back-to-back instructions on the same unit are accepted in cycles c and c + length + L + 1.
- R9: A request whose destination is being written by the other unit is held until that writer's done cycle has passed. The two units never write the same register in the same cycle.
- R10: A request whose destination is a source of the other unit's in-flight instruction is held until that instruction has read its last element. A request issued right behind an add of length n is therefore accepted in cycle c + n + 1.
- R11: An add and a multiply on unrelated registers run concurrently, and each completes at its own R6 time.
- R12: Writing the vector length while an instruction is in flight does not change how many elements that instruction processes.
- R13: A destination that is also a source of the same instruction gives the sequential elementwise result.
- R14: Each accepted instruction produces exactly one single-cycle pulse on its unit's done output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vl_we | input | 1 | Load the vector-length register |
| vl_val | input | 6 | New vector length (0 means 64) |
| iss_valid | input | 1 | Instruction request |
| iss_op | input | 1 | 0 selects the adder, 1 the multiplier |
| iss_dst | input | 3 | Destination register |
| iss_srca | input | 3 | First source register |
| iss_srcb | input | 3 | Second source register |
| iss_bsc | input | 1 | Use the scalar as the second source |
| iss_scalar | input | 64 | Broadcast scalar |
| iss_ready | output | 1 | The request is accepted at this edge when valid |
| fill_we | input | 1 | Write one element through the fill port |
| fill_reg | input | 3 | Fill register |
| fill_idx | input | 6 | Fill element |
| fill_data | input | 64 | Fill value |
| peek_reg | input | 3 | Peek register |
| peek_idx | input | 6 | Peek element |
| peek_data | output | 64 | Current value of the peeked element |
| done_add | output | 1 | Adder instruction wrote its last element |
| done_mul | output | 1 | Multiplier instruction wrote its last element |

## Verification
A wrong scoreboard or a wrong chaining condition shows up at the ports in two ways. Either `iss_ready` stays low for the wrong number of cycles, or a done pulse lands earlier or later than the cycle fixed by the length and latency arithmetic. Either way the fault is visible in the issue cycle or within one vector length after it. A chained read taken too early leaves stale elements behind. A forwarding path that is missing slows the consumer to full serial time. Both are exposed when the destination is peeked once the units go quiet, and the mismatch points to the exact element index. Random instruction streams mix in the orderings that hit the hazards, so register contents are compared against a sequential model after every stream.

// File: rtl/vcu_pkg.sv
package vcu_pkg;
  parameter int unsigned VCU_NREG    = 8;
  parameter int unsigned VCU_NELEM   = 64;
  parameter int unsigned VCU_EW      = 64;
  parameter int unsigned VCU_ADD_LAT = 3;
  parameter int unsigned VCU_MUL_LAT = 5;
  parameter int unsigned VCU_NUNIT   = 2;

  typedef enum logic {
    VOP_ADD = 1'b0,
    VOP_MUL = 1'b1
  } vop_e;
endpackage

// File: rtl/vcu_regfile.sv
module vcu_regfile #(
  parameter int unsigned NREG  = 8,
  parameter int unsigned NELEM = 64,
  parameter int unsigned EW    = 64,
  parameter int unsigned NW    = 2,
  parameter int unsigned NR    = 5,
  localparam int unsigned RW = $clog2(NREG),
  localparam int unsigned IW = $clog2(NELEM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we    [NW],
  input  logic [RW-1:0] wreg  [NW],
  input  logic [IW-1:0] widx  [NW],
  input  logic [EW-1:0] wdata [NW],
  input  logic          fwe,
  input  logic [RW-1:0] freg,
  input  logic [IW-1:0] fidx,
  input  logic [EW-1:0] fdata,
  input  logic [RW-1:0] rreg  [NR],
  input  logic [IW-1:0] ridx  [NR],
  output logic [EW-1:0] rdata [NR]
);
  logic [EW-1:0] mem [NREG][NELEM];

  // Unit writes follow the fill write so they take precedence.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < int'(NREG); r++)
        for (int i = 0; i < int'(NELEM); i++)
          mem[r][i] <= '0;
    end else begin
      if (fwe) mem[freg][fidx] <= fdata;
      for (int w = 0; w < int'(NW); w++)
        if (we[w]) mem[wreg[w]][widx[w]] <= wdata[w];
    end
  end

  // Reads see a write landing in the same cycle: this is the chaining path.
  always_comb begin
    for (int p = 0; p < int'(NR); p++) begin
      rdata[p] = mem[rreg[p]][ridx[p]];
      for (int w = 0; w < int'(NW); w++)
        if (we[w] && wreg[w] == rreg[p] && widx[w] == ridx[p])
          rdata[p] = wdata[w];
    end
  end
endmodule

// File: rtl/vcu_scoreboard.sv
module vcu_scoreboard #(
  parameter int unsigned NREG = 8,
  parameter int unsigned NU   = 2,
  localparam int unsigned RW = $clog2(NREG)
) (
  input  logic            u_busy    [NU],
  input  logic            u_reading [NU],
  input  logic            u_bsc     [NU],
  input  logic [RW-1:0]   u_dst     [NU],
  input  logic [RW-1:0]   u_srca    [NU],
  input  logic [RW-1:0]   u_srcb    [NU],
  output logic [NREG-1:0] wr_busy,
  output logic [NREG-1:0] wr_unit,
  output logic [NREG-1:0] rd_busy
);
  always_comb begin
    wr_busy = '0;
    wr_unit = '0;
    rd_busy = '0;
    for (int r = 0; r < int'(NREG); r++) begin
      for (int u = 0; u < int'(NU); u++) begin
        if (u_busy[u] && u_dst[u] == RW'(r)) begin
          wr_busy[r] = 1'b1;
          wr_unit[r] = (u != 0);
        end
        if (u_reading[u] && (u_srca[u] == RW'(r) ||
                             (!u_bsc[u] && u_srcb[u] == RW'(r))))
          rd_busy[r] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vcu_unit.sv
module vcu_unit
  import vcu_pkg::*;
#(
  parameter vop_e        OP    = VOP_ADD,
  parameter int unsigned LAT   = 3,
  parameter int unsigned NREG  = 8,
  parameter int unsigned NELEM = 64,
  parameter int unsigned EW    = 64,
  localparam int unsigned RW = $clog2(NREG),
  localparam int unsigned IW = $clog2(NELEM),
  localparam int unsigned CW = $clog2(NELEM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [RW-1:0] st_dst,
  input  logic [RW-1:0] st_a,
  input  logic [RW-1:0] st_b,
  input  logic          st_bsc,
  input  logic [EW-1:0] st_scalar,
  input  logic [CW-1:0] st_len,
  input  logic          a_ok,
  input  logic          b_ok,
  input  logic [EW-1:0] opa,
  input  logic [EW-1:0] opb,
  output logic [RW-1:0] src_a,
  output logic [RW-1:0] src_b,
  output logic          src_bsc,
  output logic [IW-1:0] rd_idx,
  output logic [RW-1:0] dst,
  output logic [CW-1:0] len,
  output logic          busy,
  output logic          reading,
  output logic          fire,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [EW-1:0] wr_data,
  output logic [CW-1:0] wr_cnt,
  output logic          done
);
  function automatic logic [EW-1:0] elem_op(input logic [EW-1:0] x, input logic [EW-1:0] y);
    if (OP == VOP_ADD) return x + y;
    else               return x * y;
  endfunction

  logic          active;
  logic [CW-1:0] idx_q, len_q, wcnt_q;
  logic [RW-1:0] dst_q, a_q, b_q;
  logic          bsc_q;
  logic [EW-1:0] scal_q;
  logic [LAT-1:0] pv, plast;
  logic [IW-1:0] pidx [LAT];
  logic [EW-1:0] pdat [LAT];
  logic          at_last;
  logic [EW-1:0] rhs;

  assign fire    = active && a_ok && b_ok;
  assign at_last = (idx_q + CW'(1)) == len_q;
  assign rhs     = bsc_q ? scal_q : opb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx_q  <= '0;
      len_q  <= '0;
      wcnt_q <= '0;
      dst_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      bsc_q  <= 1'b0;
      scal_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx_q  <= '0;
      len_q  <= st_len;
      wcnt_q <= '0;
      dst_q  <= st_dst;
      a_q    <= st_a;
      b_q    <= st_b;
      bsc_q  <= st_bsc;
      scal_q <= st_scalar;
    end else begin
      if (fire) begin
        idx_q <= idx_q + CW'(1);
        if (at_last) active <= 1'b0;
      end
      if (wr_en) wcnt_q <= wcnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv    <= '0;
      plast <= '0;
    end else begin
      pv[0]    <= fire;
      plast[0] <= fire && at_last;
      for (int k = 1; k < int'(LAT); k++) begin
        pv[k]    <= pv[k-1];
        plast[k] <= plast[k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    pidx[0] <= idx_q[IW-1:0];
    pdat[0] <= elem_op(opa, rhs);
    for (int k = 1; k < int'(LAT); k++) begin
      pidx[k] <= pidx[k-1];
      pdat[k] <= pdat[k-1];
    end
  end

  assign src_a   = a_q;
  assign src_b   = b_q;
  assign src_bsc = bsc_q;
  assign rd_idx  = idx_q[IW-1:0];
  assign dst     = dst_q;
  assign len     = len_q;
  assign busy    = active || (|pv);
  assign reading = active;
  assign wr_en   = pv[LAT-1];
  assign wr_idx  = pidx[LAT-1];
  assign wr_data = pdat[LAT-1];
  assign wr_cnt  = wcnt_q;
  assign done    = pv[LAT-1] && plast[LAT-1];
endmodule

// File: rtl/vec_chain_unit.sv
module vec_chain_unit
  import vcu_pkg::*;
#(
  parameter int unsigned NREG    = VCU_NREG,
  parameter int unsigned NELEM   = VCU_NELEM,
  parameter int unsigned EW      = VCU_EW,
  parameter int unsigned ADD_LAT = VCU_ADD_LAT,
  parameter int unsigned MUL_LAT = VCU_MUL_LAT,
  localparam int unsigned RW = $clog2(NREG),
  localparam int unsigned IW = $clog2(NELEM),
  localparam int unsigned CW = $clog2(NELEM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vl_we,
  input  logic [IW-1:0] vl_val,
  input  logic          iss_valid,
  input  logic          iss_op,
  input  logic [RW-1:0] iss_dst,
  input  logic [RW-1:0] iss_srca,
  input  logic [RW-1:0] iss_srcb,
  input  logic          iss_bsc,
  input  logic [EW-1:0] iss_scalar,
  output logic          iss_ready,
  input  logic          fill_we,
  input  logic [RW-1:0] fill_reg,
  input  logic [IW-1:0] fill_idx,
  input  logic [EW-1:0] fill_data,
  input  logic [RW-1:0] peek_reg,
  input  logic [IW-1:0] peek_idx,
  output logic [EW-1:0] peek_data,
  output logic          done_add,
  output logic          done_mul
);
  localparam int unsigned NU = VCU_NUNIT;
  localparam int unsigned NR = 2 * NU + 1;

  logic [IW-1:0] vl_q;
  logic [CW-1:0] vl_len;

  always_ff @(posedge clk) begin
    if (!rst_n)     vl_q <= '0;
    else if (vl_we) vl_q <= vl_val;
  end
  assign vl_len = (vl_q == '0) ? CW'(NELEM) : CW'(vl_q);

  logic          u_start   [NU];
  logic          u_busy    [NU];
  logic          u_reading [NU];
  logic          u_fire    [NU];
  logic          u_bsc     [NU];
  logic [RW-1:0] u_dst     [NU];
  logic [RW-1:0] u_srca    [NU];
  logic [RW-1:0] u_srcb    [NU];
  logic [IW-1:0] u_ridx    [NU];
  logic [CW-1:0] u_len     [NU];
  logic          u_we      [NU];
  logic [RW-1:0] u_wreg    [NU];
  logic [IW-1:0] u_widx    [NU];
  logic [EW-1:0] u_wdata   [NU];
  logic [CW-1:0] u_wcnt    [NU];
  logic          u_done    [NU];
  logic          u_aok     [NU];
  logic          u_bok     [NU];

  logic [RW-1:0] rf_rreg  [NR];
  logic [IW-1:0] rf_ridx  [NR];
  logic [EW-1:0] rf_rdata [NR];

  logic [NREG-1:0] wr_busy, wr_unit, rd_busy;
  logic iss_acc;

  vcu_scoreboard #(.NREG(NREG), .NU(NU)) u_sb (
    .u_busy(u_busy), .u_reading(u_reading), .u_bsc(u_bsc),
    .u_dst(u_dst), .u_srca(u_srca), .u_srcb(u_srcb),
    .wr_busy(wr_busy), .wr_unit(wr_unit), .rd_busy(rd_busy)
  );

  // Hold a request while its unit works, its destination is written (WAW)
  // or its destination is still read by the other unit (WAR).
  assign iss_ready = !u_busy[iss_op] && !wr_busy[iss_dst] && !rd_busy[iss_dst];
  assign iss_acc   = iss_valid && iss_ready;

  for (genvar u = 0; u < int'(NU); u++) begin : g_unit
    localparam int OTH = 1 - u;
    localparam vop_e UOP = (u == 0) ? VOP_ADD : VOP_MUL;
    localparam int unsigned ULAT = (u == 0) ? ADD_LAT : MUL_LAT;

    logic ch_a, ch_b, got_a, got_b;

    assign u_start[u] = iss_acc && (iss_op == 1'(u));

    // A source is chained while the other unit owns it as destination.
    assign ch_a  = wr_busy[u_srca[u]] && (wr_unit[u_srca[u]] == 1'(OTH));
    assign ch_b  = wr_busy[u_srcb[u]] && (wr_unit[u_srcb[u]] == 1'(OTH));
    assign got_a = (u_wcnt[OTH] > CW'(u_ridx[u])) ||
                   (u_we[OTH] && u_widx[OTH] == u_ridx[u]);
    assign got_b = (u_wcnt[OTH] > CW'(u_ridx[u])) ||
                   (u_we[OTH] && u_widx[OTH] == u_ridx[u]);
    assign u_aok[u] = !ch_a || got_a;
    assign u_bok[u] = u_bsc[u] || !ch_b || got_b;

    assign rf_rreg[2*u]   = u_srca[u];
    assign rf_ridx[2*u]   = u_ridx[u];
    assign rf_rreg[2*u+1] = u_srcb[u];
    assign rf_ridx[2*u+1] = u_ridx[u];
    assign u_wreg[u]      = u_dst[u];

    vcu_unit #(
      .OP(UOP), .LAT(ULAT), .NREG(NREG), .NELEM(NELEM), .EW(EW)
    ) u_fu (
      .clk(clk), .rst_n(rst_n),
      .start(u_start[u]), .st_dst(iss_dst), .st_a(iss_srca), .st_b(iss_srcb),
      .st_bsc(iss_bsc), .st_scalar(iss_scalar), .st_len(vl_len),
      .a_ok(u_aok[u]), .b_ok(u_bok[u]),
      .opa(rf_rdata[2*u]), .opb(rf_rdata[2*u+1]),
      .src_a(u_srca[u]), .src_b(u_srcb[u]), .src_bsc(u_bsc[u]),
      .rd_idx(u_ridx[u]), .dst(u_dst[u]), .len(u_len[u]),
      .busy(u_busy[u]), .reading(u_reading[u]), .fire(u_fire[u]),
      .wr_en(u_we[u]), .wr_idx(u_widx[u]), .wr_data(u_wdata[u]),
      .wr_cnt(u_wcnt[u]), .done(u_done[u])
    );
  end

  assign rf_rreg[NR-1] = peek_reg;
  assign rf_ridx[NR-1] = peek_idx;
  assign peek_data     = rf_rdata[NR-1];

  vcu_regfile #(.NREG(NREG), .NELEM(NELEM), .EW(EW), .NW(NU), .NR(NR)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(u_we), .wreg(u_wreg), .widx(u_widx), .wdata(u_wdata),
    .fwe(fill_we), .freg(fill_reg), .fidx(fill_idx), .fdata(fill_data),
    .rreg(rf_rreg), .ridx(rf_ridx), .rdata(rf_rdata)
  );

  assign done_add = u_done[0];
  assign done_mul = u_done[1];

  // Named events for the checker
  logic          add_we, mul_we, add_busy, mul_busy;
  logic [RW-1:0] add_wreg, mul_wreg;
  logic [IW-1:0] add_widx, mul_widx;
  logic [CW-1:0] add_vlen, mul_vlen;
  assign add_we   = u_we[0];
  assign mul_we   = u_we[1];
  assign add_busy = u_busy[0];
  assign mul_busy = u_busy[1];
  assign add_wreg = u_wreg[0];
  assign mul_wreg = u_wreg[1];
  assign add_widx = u_widx[0];
  assign mul_widx = u_widx[1];
  assign add_vlen = u_len[0];
  assign mul_vlen = u_len[1];
endmodule

// File: rtl/vcu_chk.sv
module vcu_chk #(
  parameter int unsigned RW = 3,
  parameter int unsigned IW = 6,
  parameter int unsigned CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iss_acc,
  input logic          iss_op,
  input logic          add_we,
  input logic          mul_we,
  input logic [RW-1:0] add_wreg,
  input logic [RW-1:0] mul_wreg,
  input logic [IW-1:0] add_widx,
  input logic [IW-1:0] mul_widx,
  input logic [CW-1:0] add_vlen,
  input logic [CW-1:0] mul_vlen,
  input logic          add_busy,
  input logic          mul_busy,
  input logic          done_add,
  input logic          done_mul
);
  // R9
  no_dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (add_we && mul_we) |-> (add_wreg != mul_wreg));

  // R14
  add_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_add |=> !done_add);

  // R14
  mul_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_mul |=> !done_mul);

  // R2
  add_last_elem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_add |-> (CW'(add_widx) + CW'(1) == add_vlen));

  // R2
  mul_last_elem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_mul |-> (CW'(mul_widx) + CW'(1) == mul_vlen));

  // R2
  add_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_we |-> (CW'(add_widx) < add_vlen));

  // R8
  add_busy_after_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_acc && !iss_op) |=> add_busy);

  // R8
  mul_busy_after_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_acc && iss_op) |=> mul_busy);
endmodule

bind vec_chain_unit vcu_chk #(.RW(RW), .IW(IW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_acc(iss_acc), .iss_op(iss_op),
  .add_we(add_we), .mul_we(mul_we), .add_wreg(add_wreg), .mul_wreg(mul_wreg),
  .add_widx(add_widx), .mul_widx(mul_widx), .add_vlen(add_vlen), .mul_vlen(mul_vlen),
  .add_busy(add_busy), .mul_busy(mul_busy), .done_add(done_add), .done_mul(done_mul)
);

// File: tb/tb_vec_chain_unit.sv
module tb_vec_chain_unit;
  localparam int CLK_P = 10;
  localparam int NREG = 8, NELEM = 64, ALAT = 3, MLAT = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vl_we = 0; logic [5:0] vl_val = 0;
  logic iss_valid = 0, iss_op = 0, iss_bsc = 0;
  logic [2:0] iss_dst = 0, iss_srca = 0, iss_srcb = 0;
  logic [63:0] iss_scalar = 0;
  logic iss_ready;
  logic fill_we = 0; logic [2:0] fill_reg = 0; logic [5:0] fill_idx = 0;
  logic [63:0] fill_data = 0;
  logic [2:0] peek_reg = 0; logic [5:0] peek_idx = 0;
  logic [63:0] peek_data;
  logic done_add, done_mul;

  vec_chain_unit dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int cyc = 0, checks = 0, errors = 0;
  int last_da = -1, last_dm = -1, n_da = 0, n_dm = 0, n_add = 0, n_mul = 0;
  int cur_len = 64;
  logic [63:0] refm [NREG][NELEM];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (rst_n && done_add) begin last_da = cyc; n_da++; end
    if (rst_n && done_mul) begin last_dm = cyc; n_dm++; end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    checks++; errors++;
    $display("FAIL watchdog: run hung, cycle %0d expected below 150000", cyc);
    finish_run();
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] f_add(input logic [63:0] x, input logic [63:0] y);
    logic [64:0] s = {1'b0, x} + {1'b0, y};
    return s[63:0];
  endfunction

  function automatic logic [63:0] f_mul(input logic [63:0] x, input logic [63:0] y);
    logic [63:0] acc = '0;
    for (int k = 0; k < 64; k++) if (y[k]) acc = acc + (x << k);
    return acc;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic fill_vec(input int r);
    for (int i = 0; i < NELEM; i++) begin
      @(negedge clk);
      fill_we = 1; fill_reg = 3'(r); fill_idx = 6'(i); fill_data = rnd64();
      refm[r][i] = fill_data;
    end
    @(negedge clk); fill_we = 0;
  endtask

  task automatic set_len(input int n);
    @(negedge clk);
    vl_we = 1; vl_val = 6'(n % 64); cur_len = n;
    @(negedge clk); vl_we = 0;
  endtask

  // Issue at a negedge, wait for acceptance, update the sequential model.
  task automatic issue(input bit op, input int d, input int a, input int b,
                       input bit bsc, input logic [63:0] s, output int t_acc);
    iss_valid = 1; iss_op = op; iss_dst = 3'(d); iss_srca = 3'(a);
    iss_srcb = 3'(b); iss_bsc = bsc; iss_scalar = s;
    forever begin
      #1;
      if (iss_ready) break;
      @(negedge clk);
    end
    t_acc = cyc;
    for (int i = 0; i < cur_len; i++) begin
      logic [63:0] rb = bsc ? s : refm[b][i];
      refm[d][i] = op ? f_mul(refm[a][i], rb) : f_add(refm[a][i], rb);
    end
    if (op) n_mul++; else n_add++;
    @(negedge clk);
    iss_valid = 0;
  endtask

  task automatic settle();
    repeat (160) @(negedge clk);
  endtask

  task automatic check_regs(input string tag);
    for (int r = 0; r < NREG; r++) begin
      int bad = -1;
      logic [63:0] got = 0;
      for (int i = 0; i < NELEM; i++) begin
        peek_reg = 3'(r); peek_idx = 6'(i); #1;
        if (bad < 0 && peek_data !== refm[r][i]) begin bad = i; got = peek_data; end
      end
      if (bad >= 0) check(0, $sformatf("%s V%0d[%0d]", tag, r, bad), got, refm[r][bad]);
      else check(1, tag, 0, 0);
    end
  endtask

  initial begin
    int t1, t2;
    void'($urandom(32'd20240611));
    for (int r = 0; r < NREG; r++) for (int i = 0; i < NELEM; i++) refm[r][i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check(done_add == 0 && done_mul == 0, "R1 done low", {done_add, done_mul}, 0);
    iss_dst = 3; #1;
    check(iss_ready == 1, "R1 ready after reset", iss_ready, 1);
    check_regs("R1 zero regs");

    for (int r = 0; r < NREG; r++) fill_vec(r);

    // R3 R6 unchained add, full length (vl_val 0 encodes 64 per R2)
    set_len(64);
    issue(0, 3, 1, 2, 0, 0, t1); settle();
    check(last_da == t1 + 64 + ALAT, "R6 add done cycle", last_da - t1, 64 + ALAT);
    check_regs("R3 add");

    // R4 R6 unchained multiply
    issue(1, 4, 1, 2, 0, 0, t1); settle();
    check(last_dm == t1 + 64 + MLAT, "R6 mul done cycle", last_dm - t1, 64 + MLAT);
    check_regs("R4 mul");

    // R2 partial length leaves tail untouched
    set_len(5);
    issue(0, 5, 1, 2, 0, 0, t1); settle();
    check(last_da == t1 + 5 + ALAT, "R2 short add done", last_da - t1, 5 + ALAT);
    check_regs("R2 partial length");

    // R5 scalar broadcast, srcb points at a register that must be ignored
    set_len(64);
    issue(0, 6, 1, 7, 1, 64'hDEAD_BEEF_0123_4567, t1);
    issue(1, 0, 2, 7, 1, 64'h0000_0001_0000_0003, t2); settle();
    check_regs("R5 scalar");

    // R7 chained add then multiply
    issue(0, 3, 1, 2, 0, 0, t1);
    issue(1, 4, 3, 2, 0, 0, t2);
    check(t2 == t1 + 1, "R7 consumer accepted next cycle", t2 - t1, 1);
    settle();
    check(last_dm == t1 + 64 + ALAT + MLAT, "R7 chained done", last_dm - t1, 64 + ALAT + MLAT);
    check_regs("R7 chained data");

    // R7 chained multiply then add (reverse direction)
    issue(1, 5, 6, 6, 0, 0, t1);
    issue(0, 7, 5, 1, 0, 0, t2); settle();
    check(last_da == t1 + 64 + MLAT + ALAT, "R7 reverse chain done", last_da - t1, 64 + MLAT + ALAT);
    check_regs("R7 reverse data");

    // R13 destination equals source
    issue(0, 1, 1, 2, 0, 0, t1); settle();
    check_regs("R13 self overlap");

    // R8 same-unit stall
    set_len(10);
    issue(0, 3, 1, 2, 0, 0, t1);
    issue(0, 4, 1, 2, 0, 0, t2); settle();
    check(t2 == t1 + 10 + ALAT + 1, "R8 same unit stall", t2 - t1, 10 + ALAT + 1);
    check_regs("R8 data");

    // R9 write-after-write hold
    set_len(20);
    issue(0, 3, 1, 2, 0, 0, t1);
    issue(1, 3, 6, 6, 0, 0, t2); settle();
    check(t2 == t1 + 20 + ALAT + 1, "R9 WAW hold", t2 - t1, 20 + ALAT + 1);
    check_regs("R9 data");

    // R10 write-after-read hold
    issue(0, 5, 1, 2, 0, 0, t1);
    issue(1, 1, 6, 6, 0, 0, t2); settle();
    check(t2 == t1 + 20 + 1, "R10 WAR hold", t2 - t1, 21);
    check_regs("R10 data");

    // R11 concurrent independent units
    set_len(64);
    issue(0, 3, 1, 2, 0, 0, t1);
    issue(1, 4, 5, 6, 0, 0, t2); settle();
    check(last_da == t1 + 64 + ALAT, "R11 add done", last_da - t1, 64 + ALAT);
    check(last_dm == t2 + 64 + MLAT && t2 == t1 + 1, "R11 mul done", last_dm - t1, 65 + MLAT);
    check_regs("R11 data");

    // R12 length change during flight
    issue(1, 7, 1, 2, 0, 0, t1);
    @(negedge clk); vl_we = 1; vl_val = 6'd4;
    @(negedge clk); vl_we = 0; cur_len = 4;
    settle();
    check(last_dm == t1 + 64 + MLAT, "R12 length kept", last_dm - t1, 64 + MLAT);
    check_regs("R12 data");

    // Random streams with hazards and chaining
    for (int blk = 0; blk < 4; blk++) begin
      for (int n = 0; n < 12; n++) begin
        if ($urandom_range(0, 5) == 0) set_len($urandom_range(1, 64));
        issue(1'($urandom_range(0, 1)), $urandom_range(0, 7), $urandom_range(0, 7),
              $urandom_range(0, 7), ($urandom_range(0, 3) == 0), rnd64(), t1);
      end
      settle();
      check_regs($sformatf("R7 R9 R10 random block %0d", blk));
    end

    // R14 one done pulse per instruction
    check(n_da == n_add, "R14 add done count", n_da, n_add);
    check(n_dm == n_mul, "R14 mul done count", n_dm, n_mul);

    finish_run();
  end
endmodule